// File: doc/BRIEF.md
# Instruction fetch sampling unit

This block watches the instruction fetch stream and builds a detailed record of one fetch at a time. Software programs a sampling period, counted in fetched instructions. While the block is counting, each fetch-start event advances the count. Once the programmed number of fetches has gone by, the next fetch start is chosen. The block keeps its address and tag, and its latency counter starts to run.

The sample is committed only when that fetch resolves. This is the first fetch-end event whose tag matches the chosen fetch, whether the fetch completed or was aborted. The committed record holds the following fields:
- the fetch address;
- a completed/aborted flag;
- the instruction-cache miss flag;
- the first-level translation-buffer miss flag;
- the second-level translation-buffer miss flag;
- the translation page size;
- the fetch latency in clock cycles.

The record stays valid and unchanged until software acknowledges it. The acknowledge reloads the period count, and sampling then begins again.

Top module: `fetch_sampler`

## Requirements
- R1: After reset `smp_valid` is 0, all record outputs are 0, and the fetch count is 0.
- R2: With `cfg_period` = P, the first P fetch starts after reset or after an accepted acknowledge are only counted. The fetch start after them is selected. With P = 0 the first fetch start is selected.
- R3: The record becomes valid only in the cycle after a fetch-end event that matches the selected fetch. It is never valid earlier.
- R4: A fetch-end event matches only when `fe_tag` equals the tag of the selected fetch. Fetch ends with other tags, and fetch ends that arrive when no fetch is tracked, have no effect. The committed `smp_addr` is the address of the selected fetch start.
- R5: The record captures the flags of the matching fetch end: `smp_aborted` (1 = aborted, 0 = completed), `smp_ic_miss`, `smp_tlb1_miss` and `smp_tlb2_miss`.
- R6: `smp_page` captures `fe_page` of the matching fetch end unchanged.
- R7: `smp_latency` equals the number of clock cycles from the cycle of the selected fetch start to the cycle of its matching end. An end in the next cycle gives 1.
- R8: The latency is 16 bits wide by default. It saturates at 65535 instead of wrapping.
- R9: While the record is valid and not acknowledged, no fetch is selected and fetch starts are not counted. The record outputs do not change, and later fetch ends do not alter them.
- R10: An acknowledge while the record is valid clears `smp_valid` in the next cycle and resets the fetch count to 0. An acknowledge while the record is not valid has no effect.
- R11: Only one fetch is tracked at a time. Fetch starts that arrive while a fetch is being tracked are neither counted nor selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_period | input | PW (8) | Number of fetches skipped before one is selected |
| fs_valid | input | 1 | Fetch-start event |
| fs_addr | input | AW (32) | Address of the starting fetch |
| fs_tag | input | TW (4) | Tag of the starting fetch |
| fe_valid | input | 1 | Fetch-end event |
| fe_tag | input | TW (4) | Tag of the ending fetch |
| fe_aborted | input | 1 | 1 = fetch aborted, 0 = completed |
| fe_ic_miss | input | 1 | Fetch missed in the instruction cache |
| fe_tlb1_miss | input | 1 | Fetch missed in the first-level translation buffer |
| fe_tlb2_miss | input | 1 | Fetch missed in the second-level translation buffer |
| fe_page | input | PGW (2) | Page-size code of the translation |
| smp_ack | input | 1 | Software acknowledge of the record |
| smp_valid | output | 1 | Sample record is valid |
| smp_addr | output | AW (32) | Captured fetch address |
| smp_aborted | output | 1 | Captured aborted flag |
| smp_ic_miss | output | 1 | Captured instruction-cache miss flag |
| smp_tlb1_miss | output | 1 | Captured first-level translation miss flag |
| smp_tlb2_miss | output | 1 | Captured second-level translation miss flag |
| smp_page | output | PGW (2) | Captured page-size code |
| smp_latency | output | LW (16) | Captured fetch latency in cycles |

## Verification
Some properties are checked on every cycle:
- no selection happens while a record is held or a fetch is tracked;
- the record stays frozen until it is acknowledged;
- a commit only ever follows tracking;
- the latency steps by one and then sticks at its maximum;
- an acknowledge clears the fetch count.

Only the bench scenarios can show the rest:
- that exactly the fetch numbered P is chosen, across a sweep of periods;
- that ends with non-matching tags are ignored;
- that every captured field belongs to the right events;
- that the measured latency equals the cycle distance between start and end, including the 65535 limit.

// File: rtl/fsamp_pkg.sv
package fsamp_pkg;

  typedef enum logic [1:0] {
    ST_COUNT = 2'd0,
    ST_TRACK = 2'd1,
    ST_HOLD  = 2'd2
  } fs_state_e;

  typedef struct packed {
    logic aborted;
    logic ic_miss;
    logic tlb1_miss;
    logic tlb2_miss;
  } fs_flags_t;

endpackage

// File: rtl/fs_period.sv
module fs_period #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] cfg_period,
  input  logic          step_i,
  input  logic          clear_i,
  output logic          armed_o
);

  logic [PW-1:0] cnt_q;

  function automatic logic reached(input logic [PW-1:0] cnt, input logic [PW-1:0] lim);
    return cnt >= lim;
  endfunction

  assign armed_o = reached(cnt_q, cfg_period);

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R10: an accepted acknowledge leaves the count at zero
  assert_reload_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_q == '0));

  // R2: the count never advances once the period is reached
  assert_no_count_past_limit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_o && !clear_i) |=> (cnt_q == $past(cnt_q)));

endmodule

// File: rtl/fs_latency.sv
module fs_latency #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          run_i,
  output logic [LW-1:0] lat_upd_o
);

  localparam logic [LW-1:0] LAT_MAX = {LW{1'b1}};

  logic [LW-1:0] lat_q;

  function automatic logic [LW-1:0] sat_inc(input logic [LW-1:0] v);
    return (v == LAT_MAX) ? v : v + 1'b1;
  endfunction

  assign lat_upd_o = sat_inc(lat_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       lat_q <= '0;
    else if (start_i) lat_q <= '0;
    else if (run_i)   lat_q <= lat_upd_o;
  end

  // R8: once at the maximum, the count stays there while running
  assert_lat_hold_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && lat_q == LAT_MAX) |=> (lat_q == LAT_MAX));

  // R7: below the maximum, a running count advances by exactly one
  assert_lat_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !start_i && lat_q != LAT_MAX) |=> (lat_q == $past(lat_q) + 1'b1));

endmodule

// File: rtl/fs_record.sv
module fs_record import fsamp_pkg::*; #(
  parameter int AW  = 32,
  parameter int PGW = 2,
  parameter int LW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           commit_i,
  input  logic           release_i,
  input  logic [AW-1:0]  addr_i,
  input  fs_flags_t      flags_i,
  input  logic [PGW-1:0] page_i,
  input  logic [LW-1:0]  lat_i,
  output logic           valid_o,
  output logic [AW-1:0]  addr_o,
  output fs_flags_t      flags_o,
  output logic [PGW-1:0] page_o,
  output logic [LW-1:0]  lat_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      addr_o  <= '0;
      flags_o <= '0;
      page_o  <= '0;
      lat_o   <= '0;
    end else if (commit_i) begin
      valid_o <= 1'b1;
      addr_o  <= addr_i;
      flags_o <= flags_i;
      page_o  <= page_i;
      lat_o   <= lat_i;
    end else if (release_i) begin
      valid_o <= 1'b0;
    end
  end

  // R10: an accepted acknowledge drops the valid flag
  assert_valid_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |=> !valid_o);

  // R3: valid rises only through a commit
  assert_rise_needs_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !commit_i) |=> !valid_o);

endmodule

// File: rtl/fetch_sampler.sv
module fetch_sampler import fsamp_pkg::*; #(
  parameter int AW  = 32,
  parameter int TW  = 4,
  parameter int PW  = 8,
  parameter int PGW = 2,
  parameter int LW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [PW-1:0]  cfg_period,
  input  logic           fs_valid,
  input  logic [AW-1:0]  fs_addr,
  input  logic [TW-1:0]  fs_tag,
  input  logic           fe_valid,
  input  logic [TW-1:0]  fe_tag,
  input  logic           fe_aborted,
  input  logic           fe_ic_miss,
  input  logic           fe_tlb1_miss,
  input  logic           fe_tlb2_miss,
  input  logic [PGW-1:0] fe_page,
  input  logic           smp_ack,
  output logic           smp_valid,
  output logic [AW-1:0]  smp_addr,
  output logic           smp_aborted,
  output logic           smp_ic_miss,
  output logic           smp_tlb1_miss,
  output logic           smp_tlb2_miss,
  output logic [PGW-1:0] smp_page,
  output logic [LW-1:0]  smp_latency
);

  fs_state_e     st_q;
  logic [AW-1:0] trk_addr_q;
  logic [TW-1:0] trk_tag_q;

  // named internal events
  logic      armed;
  logic      sel_fire;
  logic      count_step;
  logic      end_hit;
  logic      ack_take;
  logic      tracking;
  logic [LW-1:0] lat_upd;
  fs_flags_t end_flags;
  fs_flags_t rec_flags;

  function automatic logic tag_match(input logic [TW-1:0] a, input logic [TW-1:0] b);
    return a == b;
  endfunction

  assign tracking   = (st_q == ST_TRACK);
  assign sel_fire   = (st_q == ST_COUNT) && fs_valid && armed;
  assign count_step = (st_q == ST_COUNT) && fs_valid && !armed;
  assign end_hit    = tracking && fe_valid && tag_match(fe_tag, trk_tag_q);
  assign ack_take   = (st_q == ST_HOLD) && smp_ack;

  assign end_flags = '{aborted: fe_aborted, ic_miss: fe_ic_miss,
                       tlb1_miss: fe_tlb1_miss, tlb2_miss: fe_tlb2_miss};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_COUNT;
      trk_addr_q <= '0;
      trk_tag_q  <= '0;
    end else begin
      unique case (st_q)
        ST_COUNT: if (sel_fire) begin
          st_q       <= ST_TRACK;
          trk_addr_q <= fs_addr;
          trk_tag_q  <= fs_tag;
        end
        ST_TRACK: if (end_hit) st_q <= ST_HOLD;
        ST_HOLD:  if (ack_take) st_q <= ST_COUNT;
        default:  st_q <= ST_COUNT;
      endcase
    end
  end

  fs_period #(.PW(PW)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_period (cfg_period),
    .step_i     (count_step),
    .clear_i    (ack_take),
    .armed_o    (armed)
  );

  fs_latency #(.LW(LW)) u_latency (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (sel_fire),
    .run_i     (tracking),
    .lat_upd_o (lat_upd)
  );

  fs_record #(.AW(AW), .PGW(PGW), .LW(LW)) u_record (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (end_hit),
    .release_i (ack_take),
    .addr_i    (trk_addr_q),
    .flags_i   (end_flags),
    .page_i    (fe_page),
    .lat_i     (lat_upd),
    .valid_o   (smp_valid),
    .addr_o    (smp_addr),
    .flags_o   (rec_flags),
    .page_o    (smp_page),
    .lat_o     (smp_latency)
  );

  assign smp_aborted   = rec_flags.aborted;
  assign smp_ic_miss   = rec_flags.ic_miss;
  assign smp_tlb1_miss = rec_flags.tlb1_miss;
  assign smp_tlb2_miss = rec_flags.tlb2_miss;

  // R9: no selection while a record is held
  assert_no_select_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !sel_fire);

  // R9: the held record is frozen until acknowledged
  assert_record_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ack) |=> (smp_valid && $stable(smp_addr) && $stable(smp_latency)
                                 && $stable(smp_page) && $stable(rec_flags)));

  // R3: a commit follows tracking
  assert_commit_from_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) |-> $past(tracking));

  // R11: one tracked fetch at a time
  assert_single_track_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tracking |-> !sel_fire);

endmodule

// File: tb/fetch_sampler_bench.sv
module fetch_sampler_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  cfg_period;
  logic        fs_valid;
  logic [31:0] fs_addr;
  logic [3:0]  fs_tag;
  logic        fe_valid;
  logic [3:0]  fe_tag;
  logic        fe_aborted, fe_ic_miss, fe_tlb1_miss, fe_tlb2_miss;
  logic [1:0]  fe_page;
  logic        smp_ack;
  logic        smp_valid;
  logic [31:0] smp_addr;
  logic        smp_aborted, smp_ic_miss, smp_tlb1_miss, smp_tlb2_miss;
  logic [1:0]  smp_page;
  logic [15:0] smp_latency;

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  fetch_sampler u_fetch_sampler (
    .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period),
    .fs_valid(fs_valid), .fs_addr(fs_addr), .fs_tag(fs_tag),
    .fe_valid(fe_valid), .fe_tag(fe_tag), .fe_aborted(fe_aborted),
    .fe_ic_miss(fe_ic_miss), .fe_tlb1_miss(fe_tlb1_miss), .fe_tlb2_miss(fe_tlb2_miss),
    .fe_page(fe_page), .smp_ack(smp_ack),
    .smp_valid(smp_valid), .smp_addr(smp_addr), .smp_aborted(smp_aborted),
    .smp_ic_miss(smp_ic_miss), .smp_tlb1_miss(smp_tlb1_miss), .smp_tlb2_miss(smp_tlb2_miss),
    .smp_page(smp_page), .smp_latency(smp_latency)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    fs_valid = 0; fe_valid = 0; smp_ack = 0;
  endtask

  task automatic idle();
    @(negedge clk); quiet();
  endtask

  task automatic start(input logic [31:0] a, input logic [3:0] t);
    @(negedge clk); quiet();
    fs_valid = 1; fs_addr = a; fs_tag = t;
  endtask

  task automatic fend(input logic [3:0] t, input logic [3:0] fl, input logic [1:0] pg);
    @(negedge clk); quiet();
    fe_valid = 1; fe_tag = t;
    fe_aborted = fl[0]; fe_ic_miss = fl[1]; fe_tlb1_miss = fl[2]; fe_tlb2_miss = fl[3];
    fe_page = pg;
  endtask

  task automatic ack();
    @(negedge clk); quiet(); smp_ack = 1;
  endtask

  function automatic logic [31:0] addr_of(input int k, input int i);
    return 32'h1000_0000 + 32'(k * 256) + 32'(i * 4);
  endfunction

  task automatic run_trial(input int k, input int p, input int w, input bit mid_ack);
    int n = p + 3;
    int s_cyc = 0;
    int e_cyc;
    logic [3:0] fl = 4'(k);
    logic [1:0] pg = 2'((k + 1) % 4);
    @(negedge clk); quiet(); cfg_period = 8'(p);
    for (int i = 0; i < n; i++) begin
      if (mid_ack && i == 1) begin
        ack(); // R10: ack with no valid record is ignored
      end
      start(addr_of(k, i), 4'(i));
      if (i == p) s_cyc = cyc;
    end
    fend(4'(p + 1), ~fl, ~pg);
    idle();
    check("R4 nonmatching end ignored", smp_valid, 0);
    for (int j = 0; j < w; j++) idle();
    fend(4'(p), fl, pg);
    e_cyc = cyc;
    idle();
    check("R3 valid after matching end", smp_valid, 1);
    check("R2/R4 selected address", smp_addr, addr_of(k, p));
    check("R5 flags", {smp_tlb2_miss, smp_tlb1_miss, smp_ic_miss, smp_aborted}, fl);
    check("R6 page size", smp_page, pg);
    check("R7 latency", smp_latency, 64'(e_cyc - s_cyc));
    // R9: held record unaffected by further traffic
    start(32'hDEAD_0000, 4'(p));
    start(32'hDEAD_0004, 4'(p + 1));
    fend(4'(p), ~fl, ~pg);
    idle();
    check("R9 still valid", smp_valid, 1);
    check("R9 addr frozen", smp_addr, addr_of(k, p));
    check("R9 flags frozen", {smp_tlb2_miss, smp_tlb1_miss, smp_ic_miss, smp_aborted}, fl);
    ack();
    idle();
    check("R10 valid cleared by ack", smp_valid, 0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  initial begin
    #(150000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int k = 0;
    int s_cyc;
    int e_cyc;
    rst_n = 0; cfg_period = 0; fs_addr = 0; fs_tag = 0; fe_tag = 0;
    fe_aborted = 0; fe_ic_miss = 0; fe_tlb1_miss = 0; fe_tlb2_miss = 0; fe_page = 0;
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    check("R1 reset valid", smp_valid, 0);
    check("R1 reset addr", smp_addr, 0);
    check("R1 reset latency", smp_latency, 0);
    // R4: end with no tracked fetch; R11: start during tracking not selected
    cfg_period = 0;
    fend(4'd0, 4'hF, 2'd3);
    idle();
    check("R4 end without tracking ignored", smp_valid, 0);
    start(32'hA000_0000, 4'd2);
    start(32'hB000_0000, 4'd3);
    fend(4'd3, 4'h0, 2'd0);
    idle();
    check("R11 second start not tracked", smp_valid, 0);
    fend(4'd2, 4'h0, 2'd0);
    idle();
    check("R11 first start kept", smp_addr, 32'hA000_0000);
    ack();
    idle();
    for (int p = 0; p <= 6; p++) begin
      for (int wi = 0; wi < 3; wi++) begin
        int w = (wi == 0) ? 0 : (wi == 1) ? 1 : 4;
        run_trial(k, p, w, (p >= 2 && wi == 1));
        k++;
      end
    end
    // R8: saturation
    @(negedge clk); quiet(); cfg_period = 0;
    start(32'hC000_0000, 4'd5);
    s_cyc = cyc;
    repeat (70000) idle();
    fend(4'd5, 4'h0, 2'd1);
    e_cyc = cyc;
    idle();
    check("R8 latency saturates", smp_latency, 16'hFFFF);
    check("R8 distance exceeds limit", (e_cyc - s_cyc) > 65535, 1);
    ack();
    idle();
    summary();
    $finish;
  end

endmodule